// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. It also decides when software must be told about a slot event. Software reaches both registers through one 32-bit word. The control half is in bytes 0-1 and the status half in bytes 2-3. Writes use byte enables. Reads are combinational and need only an address.

Hardware reports three kinds of event: a card inserted, a card removed, and the attention button pressed. A strap tells the block whether the slot held a card when reset was released. The block keeps three event flags that software clears by writing ones, the presence state, and the state of an electromechanical interlock. It also keeps the indicator and power-controller fields.

The block computes one notify level from the event flags and their enables. Whenever a command or a new event changes that level, the block signals the change. With message interrupts enabled it sends a one-cycle request that carries a 5-bit vector. Otherwise it moves a level interrupt line. A control write can also ask the port to detach the card. The request is raised when a card is present, the power controller is switched off and the power indicator shows off.

Top module: `slot_hp_ctrl`

## Requirements
- R1: The register word answers at byte address BASE with the two low address bits zero; any other address reads 0 and ignores writes. Write bytes apply only where wr_be is set.
  - Control field positions: bit0 button-event enable, bit3 presence-change enable, bit4 command-done enable, bit5 hot-plug interrupt enable, bits7:6 attention indicator, bits9:8 power indicator, bit10 power controller (1 = off), bit11 interlock toggle command.
  - Indicator codes: 01 on, 10 blink, 11 off.
  - Status field positions (read bits 31:16): bit16 button pressed, bit19 presence changed, bit20 command done, bit22 presence state, bit23 interlock engaged.
  - The interlock toggle bit always reads 0.
- R2: The notify level is 1 only when the hot-plug interrupt enable is 1 and some event flag (button, presence-changed, command-done) is set together with its own enable.
- R3: A control write, or an event input that sets a flag that was clear, compares the new notify level with the stored one. If the two differ:
  - with msi_en or msix_en high, msi_req pulses and carries the vector;
  - otherwise irq follows the new level.
  - While a message mode is on, irq is left unchanged.
- R4: The three event flags clear when a 1 is written to them. A write to the status half updates the stored level without sending a message. It drops irq if no message mode is on and the level is 0.
- R5: An event whose flag is already set changes nothing and produces no notification.
- R6: Every write that touches either control byte counts as one command and sets the command-done flag in the same update.
- R7: Writing 1 to the interlock toggle bit flips the interlock-engaged status bit.
- R8: A control write detaches the card (one-cycle detach_req) when presence state is 1 and the resulting control word has power controller 1 and power indicator 11. Presence state then clears and presence-changed is set.
- R9: Insertion sets presence state and raises both presence-changed and button flags. Removal clears presence state and raises presence-changed. A card present at reset sets presence state with no flag.
- R10: While the interlock is engaged, insert and remove events are rejected: insert_err pulses and no state changes.
- R11: After reset all enables are 0, the attention indicator is off and the flags, the interlock and irq are clear. With boot_populated high: power indicator on, power controller 0 and presence 1. With boot_populated low: power indicator off, power controller 1 and presence 0.
- R12: The vector is loaded only through vec_wr/vec_in. msi_req lasts one cycle per notification, with msi_vec equal to the loaded vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_populated | input | 1 | Strap: slot held a card at reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| ev_insert | input | 1 | Card insertion event |
| ev_remove | input | 1 | Card removal event |
| ev_button | input | 1 | Attention button press |
| msi_en | input | 1 | MSI mode enabled |
| msix_en | input | 1 | MSI-X mode enabled |
| vec_wr | input | 1 | Load interrupt vector |
| vec_in | input | 5 | Vector value |
| irq | output | 1 | Level interrupt line |
| msi_req | output | 1 | One-cycle message request |
| msi_vec | output | 5 | Vector for the message |
| detach_req | output | 1 | One-cycle detach request |
| insert_err | output | 1 | One-cycle rejected insert/remove |

## Verification
The hardest state to reach from the ports is the detach. It needs a present card, an engaged interlock being released, and a control write that carries power-off and indicator-off, all in a chosen order. The bench first builds presence and the interlock through earlier rows of its table. It then fires one control write that toggles the interlock and requests power-off in a single command. A second hard case is a level that falls silently under a status write while message mode holds irq high. The bench enters message mode with irq already high and then clears the flags, so the held line and the missing message can both be seen.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int DW    = 32;
  localparam int HW    = 16;
  localparam int BE_W  = 4;
  localparam int VEC_W = 5;

  // control field positions
  localparam int B_ABE = 0;
  localparam int B_PDE = 3;
  localparam int B_CCE = 4;
  localparam int B_HIE = 5;
  localparam int B_ATT = 6;
  localparam int B_PWI = 8;
  localparam int B_PCC = 10;
  localparam int B_ILC = 11;

  // status field positions (event flags share positions with their enables)
  localparam int S_AB  = 0;
  localparam int S_PDC = 3;
  localparam int S_CC  = 4;
  localparam int S_PDS = 6;
  localparam int S_ILS = 7;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  localparam logic [HW-1:0] EVT_MASK =
    HW'((1 << S_AB) | (1 << S_PDC) | (1 << S_CC));

  localparam logic [HW-1:0] CTL_KEEP =
    HW'((1 << B_ABE) | (1 << B_PDE) | (1 << B_CCE) | (1 << B_HIE) |
        (3 << B_ATT) | (3 << B_PWI) | (1 << B_PCC));

  function automatic logic [HW-1:0] ctl_reset(input logic populated);
    logic [HW-1:0] v;
    v = '0;
    v[B_ATT +: 2] = IND_OFF;
    v[B_PWI +: 2] = populated ? IND_ON : IND_OFF;
    v[B_PCC]      = ~populated;
    return v;
  endfunction
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import slot_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              ctl_wr,
  output logic              sts_wr,
  output logic              rd_hit,
  output logic [DW-1:0]     wmask
);
  localparam logic [ADDR_W-1:0] WORD_ADDR = BASE & ~ADDR_W'(3);
  localparam int                HALF_BE   = BE_W / 2;

  logic wr_hit;

  assign wr_hit = wr_en && (wr_addr == WORD_ADDR);
  assign rd_hit = (rd_addr == WORD_ADDR);
  assign ctl_wr = wr_hit && (|wr_be[HALF_BE-1:0]);
  assign sts_wr = wr_hit && (|wr_be[BE_W-1:HALF_BE]);

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign wmask[b*8 +: 8] = {8{wr_hit & wr_be[b]}};
  end
endmodule

// File: rtl/slot_notify.sv
module slot_notify
  import slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_s,
  input  logic             lvl_next,
  input  logic             notify_ev,
  input  logic             clear_ev,
  input  logic             msg_en,
  input  logic [VEC_W-1:0] vec,
  output logic             lvl_q,
  output logic             irq,
  output logic             msi_req,
  output logic [VEC_W-1:0] msi_vec
);
  logic             send;
  logic             irq_d;
  logic             msi_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    send  = notify_ev && (lvl_next != lvl_q);
    msi_d = send && msg_en;
    vec_d = msi_d ? vec : msi_vec;
    irq_d = irq;
    if (send && !msg_en) begin
      irq_d = lvl_next;
    end else if (clear_ev && !msg_en && !lvl_next) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lvl_q   <= 1'b0;
      irq     <= 1'b0;
      msi_req <= 1'b0;
      msi_vec <= '0;
    end else begin
      lvl_q   <= lvl_next;
      irq     <= irq_d;
      msi_req <= msi_d;
      msi_vec <= vec_d;
    end
  end
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_populated,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              ev_insert,
  input  logic              ev_remove,
  input  logic              ev_button,
  input  logic              msi_en,
  input  logic              msix_en,
  input  logic              vec_wr,
  input  logic [4:0]        vec_in,
  output logic              irq,
  output logic              msi_req,
  output logic [4:0]        msi_vec,
  output logic              detach_req,
  output logic              insert_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  // decode
  logic          ctl_wr, sts_wr, rd_hit;
  logic [DW-1:0] wmask;

  slot_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_be  (wr_be),
    .rd_addr(rd_addr),
    .ctl_wr (ctl_wr),
    .sts_wr (sts_wr),
    .rd_hit (rd_hit),
    .wmask  (wmask)
  );

  // state
  logic [HW-1:0]    ctl_q, ctl_n;
  logic [HW-1:0]    ev_q, ev_w, ev_n;
  logic             pds_q, pds_n;
  logic             ils_q, ils_n;
  logic [VEC_W-1:0] vec_q;
  logic             det_n, err_n;
  logic [HW-1:0]    raise, fresh;
  logic             notify_ev, lvl_next, lvl_q;
  logic [HW-1:0]    ctl_wm, sts_wm;

  assign ctl_wm = wmask[HW-1:0] & CTL_KEEP;
  assign sts_wm = wmask[DW-1:HW] & EVT_MASK;

  always_comb begin
    // status half: write-one-to-clear on event flags
    ev_w = ev_q;
    if (sts_wr) ev_w = ev_q & ~(wr_data[DW-1:HW] & sts_wm);

    // control half: one command per write
    ctl_n = ctl_q;
    if (ctl_wr) ctl_n = (ctl_q & ~ctl_wm) | (wr_data[HW-1:0] & ctl_wm);

    ils_n = ils_q ^ (ctl_wr && wmask[B_ILC] && wr_data[B_ILC]);

    raise = '0;
    pds_n = pds_q;
    det_n = 1'b0;
    err_n = 1'b0;

    if (ctl_wr && pds_q && ctl_n[B_PCC] &&
        (ctl_n[B_PWI +: 2] == IND_OFF)) begin
      det_n        = 1'b1;
      pds_n        = 1'b0;
      raise[S_PDC] = 1'b1;
    end
    if (ctl_wr) raise[S_CC] = 1'b1;

    if (ev_insert || ev_remove) begin
      if (ils_q) begin
        err_n = 1'b1;
      end else if (ev_insert) begin
        pds_n        = 1'b1;
        raise[S_PDC] = 1'b1;
        raise[S_AB]  = 1'b1;
      end else begin
        pds_n        = 1'b0;
        raise[S_PDC] = 1'b1;
      end
    end
    if (ev_button) raise[S_AB] = 1'b1;

    fresh     = raise & ~ev_w;
    ev_n      = ev_w | raise;
    notify_ev = ctl_wr || (|fresh);
    lvl_next  = ctl_n[B_HIE] && (|(ev_n & ctl_n & EVT_MASK));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctl_q      <= ctl_reset(boot_populated);
      ev_q       <= '0;
      pds_q      <= boot_populated;
      ils_q      <= 1'b0;
      detach_req <= 1'b0;
      insert_err <= 1'b0;
    end else begin
      ctl_q      <= ctl_n;
      ev_q       <= ev_n;
      pds_q      <= pds_n;
      ils_q      <= ils_n;
      detach_req <= det_n;
      insert_err <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      vec_q <= '0;
    else if (vec_wr) vec_q <= vec_in;
  end

  slot_notify u_ntf (
    .clk      (clk),
    .rst_s    (rst_s),
    .lvl_next (lvl_next),
    .notify_ev(notify_ev),
    .clear_ev (sts_wr),
    .msg_en   (msi_en | msix_en),
    .vec      (vec_q),
    .lvl_q    (lvl_q),
    .irq      (irq),
    .msi_req  (msi_req),
    .msi_vec  (msi_vec)
  );

  // read view
  logic [HW-1:0] sts_view;
  always_comb begin
    sts_view        = ev_q;
    sts_view[S_PDS] = pds_q;
    sts_view[S_ILS] = ils_q;
    rd_data         = rd_hit ? {sts_view, ctl_q} : '0;
  end
endmodule

// File: rtl/slot_hp_ctrl_chk.sv
module slot_hp_ctrl_chk (
  input logic        clk,
  input logic        rst_s,
  input logic        ctl_wr,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [15:0] ev_q,
  input logic        pds_q,
  input logic        ils_q,
  input logic        msi_en,
  input logic        msix_en,
  input logic        irq,
  input logic        msi_req,
  input logic        detach_req,
  input logic        insert_err
);
  AST_MSG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_s)
    msi_req |-> $past(msi_en | msix_en)); // R3

  AST_LINE_HELD_IN_MSG: assert property (@(posedge clk) disable iff (!rst_s)
    $past(msi_en | msix_en) |-> $stable(irq)); // R3

  AST_CMD_DONE_SET: assert property (@(posedge clk) disable iff (!rst_s)
    ctl_wr |=> ev_q[4]); // R6

  AST_LOCK_FLIPS: assert property (@(posedge clk) disable iff (!rst_s)
    (ctl_wr && wr_be[1] && wr_data[11]) |=> (ils_q != $past(ils_q))); // R7

  AST_DETACH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_s)
    detach_req |-> (!pds_q && ev_q[3])); // R8

  AST_REJECT_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_s)
    insert_err |-> ($past(ils_q) && $stable(pds_q))); // R10
endmodule

bind slot_hp_ctrl slot_hp_ctrl_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .ctl_wr    (ctl_wr),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .ev_q      (ev_q),
  .pds_q     (pds_q),
  .ils_q     (ils_q),
  .msi_en    (msi_en),
  .msix_en   (msix_en),
  .irq       (irq),
  .msi_req   (msi_req),
  .detach_req(detach_req),
  .insert_err(insert_err)
);

// File: tb/slot_hp_ctrl_tb_top.sv
module slot_hp_ctrl_tb_top;
  localparam logic [7:0] BASE = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_populated = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = BASE;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = BASE;
  logic [31:0] rd_data;
  logic        ev_insert = 1'b0, ev_remove = 1'b0, ev_button = 1'b0;
  logic        msi_en = 1'b0, msix_en = 1'b0;
  logic        vec_wr = 1'b0;
  logic [4:0]  vec_in = '0;
  logic        irq, msi_req, detach_req, insert_err;
  logic [4:0]  msi_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slot_hp_ctrl #(.ADDR_W(8), .BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_populated(boot_populated),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_insert(ev_insert), .ev_remove(ev_remove), .ev_button(ev_button),
    .msi_en(msi_en), .msix_en(msix_en), .vec_wr(vec_wr), .vec_in(vec_in),
    .irq(irq), .msi_req(msi_req), .msi_vec(msi_vec),
    .detach_req(detach_req), .insert_err(insert_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // op: 0 register write, 1 button, 2 insert, 3 remove, other idle
  task automatic step(input int op, input logic [7:0] addr, input logic [3:0] be,
                      input logic [31:0] data);
    @(negedge clk);
    wr_en     = (op == 0);
    wr_addr   = addr;
    wr_be     = be;
    wr_data   = data;
    ev_button = (op == 1);
    ev_insert = (op == 2);
    ev_remove = (op == 3);
    @(posedge clk);
    #2;
    wr_en = 1'b0; ev_button = 1'b0; ev_insert = 1'b0; ev_remove = 1'b0;
  endtask

  task automatic do_reset(input logic pop);
    @(negedge clk);
    boot_populated = pop;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_msi;
    logic        exp_err;
    logic        exp_det;
  } row_t;

  localparam int NROW = 10;
  localparam row_t TBL [NROW] = '{
    '{2'd2, 4'h0, 32'h0000_0000, 32'h0049_07C0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 insert
    '{2'd0, 4'h3, 32'h0000_01E8, 32'h0059_01E8, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 R6 enables
    '{2'd0, 4'hC, 32'h0008_0000, 32'h0051_01E8, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 clear drops line
    '{2'd1, 4'h0, 32'h0000_0000, 32'h0051_01E8, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 already set
    '{2'd0, 4'h3, 32'h0000_01E9, 32'h0051_01E9, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 level rises
    '{2'd0, 4'hC, 32'h0011_0000, 32'h0040_01E9, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{2'd1, 4'h0, 32'h0000_0000, 32'h0041_01E9, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 new event
    '{2'd0, 4'h3, 32'h0000_09E9, 32'h00D1_01E9, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 R1 lock on
    '{2'd2, 4'h0, 32'h0000_0000, 32'h00D1_01E9, 1'b1, 1'b0, 1'b1, 1'b0}, // R10 rejected
    '{2'd0, 4'h3, 32'h0000_0FE9, 32'h0019_07E9, 1'b1, 1'b0, 1'b0, 1'b1}  // R8 R7 detach
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    do_reset(1'b0);
    chk("R11 reset rd", rd_data, 32'h0000_07C0);
    chk("R11 reset irq", {31'b0, irq}, 32'd0);
    chk("R11 reset msi", {31'b0, msi_req}, 32'd0);

    for (int i = 0; i < NROW; i++) begin
      step(int'(TBL[i].op), BASE, TBL[i].be, TBL[i].data);
      chk($sformatf("R1 row%0d rd", i), rd_data, TBL[i].exp_rd);
      chk($sformatf("R3 row%0d irq", i), {31'b0, irq}, {31'b0, TBL[i].exp_irq});
      chk($sformatf("R12 row%0d msi", i), {31'b0, msi_req}, {31'b0, TBL[i].exp_msi});
      chk($sformatf("R10 row%0d err", i), {31'b0, insert_err}, {31'b0, TBL[i].exp_err});
      chk($sformatf("R8 row%0d det", i), {31'b0, detach_req}, {31'b0, TBL[i].exp_det});
    end

    // message mode: silent clear keeps line, new event sends vector
    @(negedge clk);
    msi_en = 1'b1; vec_wr = 1'b1; vec_in = 5'd21;
    @(negedge clk);
    vec_wr = 1'b0; vec_in = 5'd0;
    step(0, BASE, 4'hC, 32'h0019_0000);
    chk("R4 silent clear rd", rd_data, 32'h0000_07E9);
    chk("R4 silent clear msi", {31'b0, msi_req}, 32'd0);
    chk("R3 line held in msg mode", {31'b0, irq}, 32'd1);
    step(1, BASE, 4'h0, 32'h0);
    chk("R3 msi on rise", {31'b0, msi_req}, 32'd1);
    chk("R12 vector", {27'b0, msi_vec}, 32'd21);
    step(4, BASE, 4'h0, 32'h0);
    chk("R12 single pulse", {31'b0, msi_req}, 32'd0);

    // MSI-X mode: level falls under a control write
    @(negedge clk);
    msi_en = 1'b0; msix_en = 1'b1;
    step(0, BASE, 4'h3, 32'h0000_07C9);
    chk("R3 msix on fall", {31'b0, msi_req}, 32'd1);
    chk("R6 cmd done rd", rd_data, 32'h0011_07C9);

    // legacy again
    @(negedge clk);
    msix_en = 1'b0;
    step(0, BASE, 4'h3, 32'h0000_07E9);
    chk("R3 legacy high", {31'b0, irq}, 32'd1);
    chk("R3 legacy no msg", {31'b0, msi_req}, 32'd0);
    step(0, BASE, 4'hC, 32'h0011_0000);
    chk("R4 legacy drop", {31'b0, irq}, 32'd0);
    chk("R4 rd", rd_data, 32'h0000_07E9);

    // other addresses
    step(0, BASE + 8'd4, 4'hF, 32'hFFFF_FFFF);
    step(0, BASE + 8'd1, 4'hF, 32'hFFFF_FFFF);
    chk("R1 foreign write ignored", rd_data, 32'h0000_07E9);
    @(negedge clk);
    rd_addr = BASE + 8'd4;
    #1;
    chk("R1 foreign read zero", rd_data, 32'h0);
    rd_addr = BASE;

    // byte enable on upper control byte only
    step(0, BASE, 4'h2, 32'h0000_0000);
    chk("R1 byte enable", rd_data, 32'h0010_00E9);
    chk("R2 no level", {31'b0, irq}, 32'd0);

    // populated boot, then removal and insertion
    do_reset(1'b1);
    chk("R11 populated reset", rd_data, 32'h0040_01C0);
    chk("R11 populated irq", {31'b0, irq}, 32'd0);
    step(3, BASE, 4'h0, 32'h0);
    chk("R9 removal", rd_data, 32'h0008_01C0);
    step(2, BASE, 4'h0, 32'h0);
    chk("R9 insertion", rd_data, 32'h0049_01C0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule